// File: doc/BRIEF.md
# Table-Lookup Ternary Matrix-Vector Engine

This block computes a matrix-vector product y = W·a. The weights W hold only -1, 0 or +1, and the activation vector a holds signed 8-bit values. No multiplier takes part. Weights are stored ahead of time in a small dual-port RAM. Each run of GRP consecutive weights in a row is packed as one base-3 code. Activations arrive as a stream with one group of GRP values per beat. For every group the engine first builds a table of all 3^GRP signed sums of those activations. Each stored code then selects one entry of that table, and the entry is added to the accumulator of its row.

LANES rows are looked up and accumulated in each cycle, one table read per lane. One group is issued per NROWS/LANES cycles with no idle cycle between groups. Two tables alternate: the next group's table is filled while the current one is being read. Once the last group has been accumulated, the NROWS results stream out one row per beat through a valid/ready handshake. A last flag marks the final row.

Top module: `tlmv_engine`

## Requirements
- R1: After reset the result stream is idle (outValid low) and the activation input is ready (actReady high).
- R2: Weight code digit i (least significant base-3 digit is element 0 of the group) selects the weight as 0 → -1, 1 → 0, 2 → +1. Each output row equals the exact signed sum over k of w[row][k]·a[k].
- R3: Weight RAM word address = group·(NROWS/LANES) + block. Bits [l·IDXW +: IDXW] of a word hold the code for row block·LANES + l, with IDXW = ceil(log2(3^GRP)). Activation beat j carries elements j·GRP … j·GRP+GRP-1, element i in bits [i·8 +: 8].
- R4: Results leave as exactly NROWS beats in row order 0 … NROWS-1. outLast is high on row NROWS-1 only, and outValid drops after that beat.
- R5: While outValid is high and outReady is low, outValid, outData and outLast hold their values.
- R6: A group is accepted whenever one of the two tables is free. After the first group of a vector is accepted, actReady stays high for a second group. With two groups pending it goes low.
- R7: If the groups of a vector are offered without gaps, outValid rises exactly NGRP·(NROWS/LANES)+1 cycles after the clock edge that accepts the first group.
- R8: Each vector starts from cleared accumulators, so no sum carries over from the previous vector.
- R9: Accumulators are 8+ceil(log2 KLEN)+1 bits wide and hold the extreme cases (every activation -128 with every weight +1 or every weight -1) without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wgtWrEn | input | 1 | Weight RAM write enable |
| wgtWrAddr | input | ADDRW | Weight RAM write address |
| wgtWrData | input | LANES·IDXW | Packed weight codes for one word |
| actValid | input | 1 | Activation group valid |
| actReady | output | 1 | Activation group accepted when high with actValid |
| actData | input | GRP·8 | Signed activation group |
| outValid | output | 1 | Result row valid |
| outReady | input | 1 | Result row taken when high with outValid |
| outData | output | ACCW | Signed result row |
| outLast | output | 1 | Marks the final row of the vector |

## Verification
Some rules are checked by assertions on every cycle. These are the hold rule of the result stream, and the rule that outLast appears only with outValid. They also cover the following:
- no accumulation happens while results drain;
- an accepted group always occupies a table;
- the all-zero code's table entry is zero after every build;
- no accumulator add ever overflows.

Other behaviour only the bench scenarios can show: the numerical result under the digit encoding and RAM layout, the exact latency when groups arrive back to back, the double-buffered acceptance pattern, and the clearing of accumulators between vectors.

// File: rtl/tlmv_pkg.sv
package tlmv_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic build;      // write a freshly computed table
    logic buildBank;  // which table bank to write
    logic accEn;      // lookup stage active this cycle
    logic accFirst;   // first group: load instead of add
    logic accBank;    // table bank read by the lookup stage
  } tlmvStrobe_t;

endpackage

// File: rtl/tlmv_tablegen.sv
module tlmv_tablegen #(
  parameter int GRP  = 3,
  parameter int TSIZE = 27,
  parameter int TABW = 10
) (
  input  logic [GRP*8-1:0]            actData,
  output logic signed [TABW-1:0]      entry [TSIZE]
);

  logic signed [TABW-1:0] actExt [GRP];

  for (genvar i = 0; i < GRP; i++) begin : g_ext
    assign actExt[i] = {{(TABW-8){actData[i*8+7]}}, actData[i*8 +: 8]};
  end

  // Entry e: digit i of e chooses -a[i], nothing, or +a[i]
  for (genvar e = 0; e < TSIZE; e++) begin : g_ent
    always_comb begin
      int dig;
      int rest;
      logic signed [TABW-1:0] sum;
      sum  = '0;
      rest = e;
      for (int i = 0; i < GRP; i++) begin
        dig  = rest % 3;
        rest = rest / 3;
        if (dig == 2)      sum = sum + actExt[i];
        else if (dig == 0) sum = sum - actExt[i];
      end
      entry[e] = sum;
    end
  end

endmodule

// File: rtl/tlmv_wram.sv
module tlmv_wram #(
  parameter int DEPTH = 16,
  parameter int ADDRW = 4,
  parameter int DW    = 10
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [ADDRW-1:0] wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic [ADDRW-1:0] rdAddr,
  output logic [DW-1:0]    rdData
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    rdData <= mem[rdAddr];
  end

endmodule

// File: rtl/tlmv_ctrl.sv
module tlmv_ctrl
  import tlmv_pkg::*;
#(
  parameter int NGRP  = 4,
  parameter int NBLK  = 4,
  parameter int NROWS = 8,
  parameter int ADDRW = 4,
  parameter int ROWW  = 3,
  parameter int BW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             actValid,
  output logic             actReady,
  input  logic             outReady,
  output logic             outValid,
  output logic             outLast,
  output logic [ROWW-1:0]  outIdx,
  output logic [ADDRW-1:0] rdAddr,
  output logic [BW-1:0]    accBlk,
  output tlmvStrobe_t      strobe
);

  localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;

  typedef enum logic [1:0] {PH_RUN, PH_FLUSH, PH_OUT} phase_t;

  phase_t          phase;
  logic [1:0]      bankFull, bankFullNext;
  logic            wrBank, rdBank;
  logic [GW-1:0]   issGrp;
  logic [BW-1:0]   issBlk;
  logic            s1Valid, s1Bank, s1First, s1LastBlk;
  logic [BW-1:0]   s1Blk;
  logic            build, issue, issLastBlk, issLastGrp;

  assign actReady   = !bankFull[wrBank];
  assign build      = actValid && actReady;
  assign issue      = (phase == PH_RUN) && bankFull[rdBank];
  assign issLastBlk = (issBlk == BW'(NBLK-1));
  assign issLastGrp = (issGrp == GW'(NGRP-1));
  assign rdAddr     = ADDRW'(int'(issGrp) * NBLK + int'(issBlk));

  always_comb begin
    bankFullNext = bankFull;
    if (build) bankFullNext[wrBank] = 1'b1;
    if (s1Valid && s1LastBlk) bankFullNext[s1Bank] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bankFull <= '0;
      wrBank   <= 1'b0;
      rdBank   <= 1'b0;
      issGrp   <= '0;
      issBlk   <= '0;
      phase    <= PH_RUN;
      outIdx   <= '0;
    end else begin
      bankFull <= bankFullNext;
      if (build) wrBank <= !wrBank;
      if (issue) begin
        if (issLastBlk) begin
          issBlk <= '0;
          rdBank <= !rdBank;
          if (issLastGrp) begin
            issGrp <= '0;
            phase  <= PH_FLUSH;
          end else begin
            issGrp <= issGrp + 1'b1;
          end
        end else begin
          issBlk <= issBlk + 1'b1;
        end
      end
      if (phase == PH_FLUSH) phase <= PH_OUT;
      if (phase == PH_OUT && outReady) begin
        if (outLast) begin
          outIdx <= '0;
          phase  <= PH_RUN;
        end else begin
          outIdx <= outIdx + 1'b1;
        end
      end
    end
  end

  // Lookup stage registers (aligned with the RAM read latency)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Valid   <= 1'b0;
      s1Bank    <= 1'b0;
      s1First   <= 1'b0;
      s1LastBlk <= 1'b0;
      s1Blk     <= '0;
    end else begin
      s1Valid   <= issue;
      s1Bank    <= rdBank;
      s1First   <= (issGrp == '0);
      s1LastBlk <= issLastBlk;
      s1Blk     <= issBlk;
    end
  end

  assign outValid = (phase == PH_OUT);
  assign outLast  = (phase == PH_OUT) && (outIdx == ROWW'(NROWS-1));
  assign accBlk   = s1Blk;

  always_comb begin
    strobe.build     = build;
    strobe.buildBank = wrBank;
    strobe.accEn     = s1Valid;
    strobe.accFirst  = s1First;
    strobe.accBank   = s1Bank;
  end

  // R6
  table_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    actValid && actReady |=> bankFull[$past(wrBank)]);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outIdx));

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outLast |-> outValid);

  // R4
  acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> !s1Valid);

endmodule

// File: rtl/tlmv_datapath.sv
module tlmv_datapath
  import tlmv_pkg::*;
#(
  parameter int GRP   = 3,
  parameter int NROWS = 8,
  parameter int LANES = 2,
  parameter int TSIZE = 27,
  parameter int IDXW  = 5,
  parameter int TABW  = 10,
  parameter int ACCW  = 13,
  parameter int DEPTH = 16,
  parameter int ADDRW = 4,
  parameter int ROWW  = 3,
  parameter int BW    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  tlmvStrobe_t           strobe,
  input  logic [GRP*8-1:0]      actData,
  input  logic                  wgtWrEn,
  input  logic [ADDRW-1:0]      wgtWrAddr,
  input  logic [LANES*IDXW-1:0] wgtWrData,
  input  logic [ADDRW-1:0]      rdAddr,
  input  logic [BW-1:0]         accBlk,
  input  logic [ROWW-1:0]       outIdx,
  output logic [ACCW-1:0]       outData
);

  localparam int ZIDX = (TSIZE - 1) / 2;  // code whose digits are all "zero weight"

  logic signed [TABW-1:0] newEntry [TSIZE];
  logic signed [TABW-1:0] tbl [2][TSIZE];
  logic [LANES*IDXW-1:0]  ramQ;
  logic signed [ACCW-1:0] acc [NROWS];
  logic signed [ACCW-1:0] laneVal [LANES];
  logic [ROWW-1:0]        laneRow [LANES];
  logic signed [ACCW:0]   laneSum [LANES];

  tlmv_tablegen #(.GRP(GRP), .TSIZE(TSIZE), .TABW(TABW)) u_tablegen (
    .actData (actData),
    .entry   (newEntry)
  );

  tlmv_wram #(.DEPTH(DEPTH), .ADDRW(ADDRW), .DW(LANES*IDXW)) u_wram (
    .clk    (clk),
    .wrEn   (wgtWrEn),
    .wrAddr (wgtWrAddr),
    .wrData (wgtWrData),
    .rdAddr (rdAddr),
    .rdData (ramQ)
  );

  always_ff @(posedge clk) begin
    if (strobe.build) begin
      for (int e = 0; e < TSIZE; e++) tbl[strobe.buildBank][e] <= newEntry[e];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDXW-1:0]        idx;
    logic signed [TABW-1:0] hit;
    assign idx = ramQ[l*IDXW +: IDXW];
    assign hit = (idx < IDXW'(TSIZE)) ? tbl[strobe.accBank][idx] : '0;
    assign laneVal[l] = {{(ACCW-TABW){hit[TABW-1]}}, hit};
    assign laneRow[l] = ROWW'(int'(accBlk) * LANES + l);
    assign laneSum[l] = {acc[laneRow[l]][ACCW-1], acc[laneRow[l]]}
                      + {laneVal[l][ACCW-1], laneVal[l]};

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.accEn && !strobe.accFirst |-> laneSum[l][ACCW] == laneSum[l][ACCW-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NROWS; r++) acc[r] <= '0;
    end else if (strobe.accEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (strobe.accFirst) acc[laneRow[l]] <= laneVal[l];
        else                 acc[laneRow[l]] <= laneSum[l][ACCW-1:0];
      end
    end
  end

  assign outData = acc[outIdx];

  // R2
  zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.build |=> tbl[$past(strobe.buildBank)][ZIDX] == '0);

endmodule

// File: rtl/tlmv_engine.sv
module tlmv_engine
  import tlmv_pkg::*;
#(
  parameter int GRP   = 3,
  parameter int KLEN  = 12,
  parameter int NROWS = 8,
  parameter int LANES = 2,
  localparam int NGRP  = KLEN / GRP,
  localparam int NBLK  = NROWS / LANES,
  localparam int TSIZE = 3 ** GRP,
  localparam int IDXW  = $clog2(TSIZE),
  localparam int DEPTH = NGRP * NBLK,
  localparam int ADDRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int TABW  = 8 + $clog2(GRP) + 1,
  localparam int ACCW  = 8 + $clog2(KLEN) + 1,
  localparam int ROWW  = (NROWS > 1) ? $clog2(NROWS) : 1,
  localparam int BW    = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wgtWrEn,
  input  logic [ADDRW-1:0]      wgtWrAddr,
  input  logic [LANES*IDXW-1:0] wgtWrData,
  input  logic                  actValid,
  output logic                  actReady,
  input  logic [GRP*8-1:0]      actData,
  output logic                  outValid,
  input  logic                  outReady,
  output logic [ACCW-1:0]       outData,
  output logic                  outLast
);

  tlmvStrobe_t      strobe;
  logic [ROWW-1:0]  outIdx;
  logic [ADDRW-1:0] rdAddr;
  logic [BW-1:0]    accBlk;

  tlmv_ctrl #(
    .NGRP(NGRP), .NBLK(NBLK), .NROWS(NROWS),
    .ADDRW(ADDRW), .ROWW(ROWW), .BW(BW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .actValid (actValid),
    .actReady (actReady),
    .outReady (outReady),
    .outValid (outValid),
    .outLast  (outLast),
    .outIdx   (outIdx),
    .rdAddr   (rdAddr),
    .accBlk   (accBlk),
    .strobe   (strobe)
  );

  tlmv_datapath #(
    .GRP(GRP), .NROWS(NROWS), .LANES(LANES), .TSIZE(TSIZE), .IDXW(IDXW),
    .TABW(TABW), .ACCW(ACCW), .DEPTH(DEPTH), .ADDRW(ADDRW), .ROWW(ROWW), .BW(BW)
  ) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .actData   (actData),
    .wgtWrEn   (wgtWrEn),
    .wgtWrAddr (wgtWrAddr),
    .wgtWrData (wgtWrData),
    .rdAddr    (rdAddr),
    .accBlk    (accBlk),
    .outIdx    (outIdx),
    .outData   (outData)
  );

endmodule

// File: tb/tlmv_engine_bench.sv
module tlmv_engine_bench;

  localparam int GRP   = 3;
  localparam int KLEN  = 12;
  localparam int NROWS = 8;
  localparam int LANES = 2;
  localparam int NGRP  = KLEN / GRP;
  localparam int NBLK  = NROWS / LANES;
  localparam int IDXW  = 5;
  localparam int ADDRW = 4;
  localparam int ACCW  = 13;
  localparam int LAT   = NGRP * NBLK + 1;

  // Stimulus table: seed, mode (0 pattern, 1 all +1 / -128, 2 all -1 / -128, 3 zero weights), stall
  localparam int NCASE = 5;
  localparam int CASE_SEED  [NCASE] = '{3, 11, 0, 0, 7};
  localparam int CASE_MODE  [NCASE] = '{0, 0, 1, 2, 3};
  localparam int CASE_STALL [NCASE] = '{0, 1, 0, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wgtWrEn = 1'b0;
  logic [ADDRW-1:0] wgtWrAddr = '0;
  logic [LANES*IDXW-1:0] wgtWrData = '0;
  logic actValid = 1'b0;
  logic actReady;
  logic [GRP*8-1:0] actData = '0;
  logic outValid;
  logic outReady = 1'b1;
  logic [ACCW-1:0] outData;
  logic outLast;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int stamp = 0;
  int wt [NROWS][KLEN];
  int av [KLEN];
  int expv [NROWS];

  always #5 clk = !clk;
  always @(posedge clk) cyc++;

  tlmv_engine u_tlmv_engine (
    .clk(clk), .rst_n(rst_n),
    .wgtWrEn(wgtWrEn), .wgtWrAddr(wgtWrAddr), .wgtWrData(wgtWrData),
    .actValid(actValid), .actReady(actReady), .actData(actData),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outLast(outLast)
  );

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic setupCase(input int seed, input int mode);
    for (int k = 0; k < KLEN; k++) begin
      av[k] = (mode == 1 || mode == 2) ? -128 : (((seed * 31 + k * 53 + 17) % 256) - 128);
    end
    for (int r = 0; r < NROWS; r++) begin
      expv[r] = 0;
      for (int k = 0; k < KLEN; k++) begin
        case (mode)
          1: wt[r][k] = 1;
          2: wt[r][k] = -1;
          3: wt[r][k] = 0;
          default: wt[r][k] = ((seed + r * 7 + k * 5 + r * k) % 3) - 1;
        endcase
        expv[r] += wt[r][k] * av[k];
      end
    end
  endtask

  // R3: address = group*NBLK + block, lane l at bits [l*IDXW +: IDXW]
  task automatic loadWeights();
    for (int g = 0; g < NGRP; g++) begin
      for (int b = 0; b < NBLK; b++) begin
        logic [LANES*IDXW-1:0] word;
        word = '0;
        for (int l = 0; l < LANES; l++) begin
          int code;
          int p;
          code = 0;
          p = 1;
          for (int i = 0; i < GRP; i++) begin
            code += (wt[b * LANES + l][g * GRP + i] + 1) * p;
            p *= 3;
          end
          word[l*IDXW +: IDXW] = IDXW'(code);
        end
        @(negedge clk);
        wgtWrEn = 1'b1;
        wgtWrAddr = ADDRW'(g * NBLK + b);
        wgtWrData = word;
      end
    end
    @(negedge clk);
    wgtWrEn = 1'b0;
  endtask

  task automatic sendVector();
    for (int g = 0; g < NGRP; g++) begin
      for (int i = 0; i < GRP; i++) actData[i*8 +: 8] = 8'(av[g * GRP + i]);
      actValid = 1'b1;
      // R6: second group taken at once, third must wait for a free table
      if (g == 1) check(actReady == 1'b1, "R6 second group ready", int'(actReady), 1);
      if (g == 2) check(actReady == 1'b0, "R6 stall with two tables pending", int'(actReady), 0);
      while (!actReady) @(negedge clk);
      @(negedge clk);
      if (g == 0) stamp = cyc;
    end
    actValid = 1'b0;
  endtask

  task automatic readVector(input bit stall);
    for (int r = 0; r < NROWS; r++) begin
      while (!outValid) @(negedge clk);
      if (r == 0) check(cyc - stamp == LAT, "R7 latency", cyc - stamp, LAT);
      check(int'($signed(outData)) == expv[r], $sformatf("R2 R8 R9 row %0d", r),
            int'($signed(outData)), expv[r]);
      check(outLast == (r == NROWS - 1), "R4 last flag", int'(outLast), int'(r == NROWS - 1));
      if (stall && (r % 3 == 1)) begin
        logic [ACCW-1:0] held;
        held = outData;
        outReady = 1'b0;
        repeat (3) @(negedge clk);
        check(outValid && outData == held && outLast == (r == NROWS - 1), "R5 hold under backpressure",
              int'($signed(outData)), int'($signed(held)));
        outReady = 1'b1;
      end
      @(negedge clk);
    end
    check(outValid == 1'b0, "R4 exactly NROWS beats", int'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(outValid == 1'b0, "R1 idle during reset", int'(outValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(actReady == 1'b1, "R1 actReady after reset", int'(actReady), 1);

    for (int c = 0; c < NCASE; c++) begin
      setupCase(CASE_SEED[c], CASE_MODE[c]);
      loadWeights();
      sendVector();
      readVector(CASE_STALL[c] != 0);
      repeat (2) @(negedge clk);
    end

    // R8: same data twice in a row gives the same result (no carry-over)
    setupCase(19, 0);
    loadWeights();
    sendVector();
    readVector(1'b0);
    sendVector();
    readVector(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule